// File: doc/BRIEF.md
# Reset Hold Duration Counter

This block measures how long an external active-low push-button or reset line stays pressed. It runs on a 25 MHz reference clock, so each count is 40 ns. The line is first brought into the clock domain through a two-stage synchroniser. After that, a 29-bit counter advances once per clock for as long as the synchronised line reads low.

When the line goes high again, the count freezes and stays readable. Firmware can then decide whether the press was long enough to mean something, for example a request to restore factory settings. If the count reaches the top of its range, it stays there instead of rolling over. A later press with no clear in between adds onto the held value.

Firmware clears the count by writing a word with bit 31 set. The read port shows the count in the low bits, and every bit above the count reads zero.

Top module: `rhold_meter`

## Requirements
- R1: While `rst_n` is low, and after it is released with `btn_n` high, `rd_data` reads zero.
- R2: `btn_n` passes through two synchroniser flops before reaching the counter. The first increment is visible on `rd_data` after the third rising clock edge at which `btn_n` is sampled low.
- R3: A press in which `btn_n` is sampled low at N consecutive rising edges (N below the maximum) raises the count by exactly N, one per clock.
- R4: The count saturates at 2^CNT_W-1 (29 bits by default) and stays at that value while the press continues or repeats.
- R5: When the synchronised line reads high, the count holds its value indefinitely. Release does not clear it.
- R6: A new press after a release, with no clear in between, continues counting from the held value.
- R7: A cycle with `wr_en` high and `wr_data` bit 31 equal to 1 sets the count to zero at that clock edge.
- R8: A write with `wr_data` bit 31 equal to 0 has no effect on the count, whatever the other bits are.
- R9: When a clear and an increment fall in the same cycle, the clear wins and the count becomes zero.
- R10: `rd_data` bits CNT_W-1:0 carry the count. Bits 31 down to CNT_W always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz reference clock |
| rst_n | input | 1 | Active-low block reset, asynchronous assert |
| btn_n | input | 1 | Asynchronous active-low press input being timed |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; bit 31 requests a clear |
| rd_data | output | 32 | Count in the low CNT_W bits, zeros above |

## Verification
The bench builds the block with CNT_W set to 6, so the count saturates at 63. That puts saturation, repeated presses against the ceiling and the exact boundary presses of 62 and 63 cycles within a few hundred clocks. The same narrow width lets the bench sweep every press length from 1 to 20 and compare each result arithmetically. It also checks the synchroniser latency edge by edge and places a clear in the middle of an active press. The wide upper field of `rd_data` then shows that every bit above the count stays zero.

// File: rtl/rhc_pkg.sv
package rhc_pkg;
    localparam int REG_W   = 32;
    localparam int CLR_POS = 31;

    typedef struct packed {
        logic clr;
        logic held;
    } ctl_t;
endpackage

// File: rtl/rhc_sync.sv
module rhc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (STAGES > 1) begin
            st_d.sh = {st_q.sh[STAGES-2:0], async_i};
        end else begin
            st_d.sh = async_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.sh[STAGES-1];
endmodule

// File: rtl/rhc_counter.sv
module rhc_counter #(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             held_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (held_i && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));

    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && held_i) |=> (cnt_o == '0));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (held_i && !clr_i && cnt_o != CNT_MAX) |=> (cnt_o == $past(cnt_o) + CNT_ONE));

    assert_sat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (held_i && !clr_i && cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX));

    assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!held_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/rhold_meter.sv
module rhold_meter #(
    parameter int CNT_W       = 29,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        btn_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data
);
    import rhc_pkg::*;

    localparam int PAD_W = REG_W - CNT_W;

    logic             btn_sync_n;
    logic [CNT_W-1:0] cnt;
    ctl_t             ctl;

    rhc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (btn_n),
        .sync_o  (btn_sync_n)
    );

    always_comb begin
        ctl.clr  = wr_en & wr_data[CLR_POS];
        ctl.held = ~btn_sync_n;
    end

    rhc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .held_i (ctl.held),
        .clr_i  (ctl.clr),
        .cnt_o  (cnt)
    );

    assign rd_data = {{PAD_W{1'b0}}, cnt};

    assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:CNT_W] == '0);

    assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[CLR_POS] && btn_sync_n) |=> $stable(rd_data));
endmodule

// File: tb/sim_rhold_meter.sv
module sim_rhold_meter;
    localparam int CW = 6;
    localparam int MAXV = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        btn_n = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;

    int n_vec = 0;
    int n_bad = 0;
    int model = 0;

    always #10 clk = ~clk;

    rhold_meter #(.CNT_W(CW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] exp);
        n_vec++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%0h expected=%0h", req, rd_data, exp);
        end
    endtask

    task automatic clear_cnt();
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h8000_0000;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        model = 0;
    endtask

    task automatic press(input int n);
        @(negedge clk);
        btn_n = 1'b0;
        repeat (n) @(negedge clk);
        btn_n = 1'b1;
        repeat (3) @(negedge clk);
        model = (model + n > MAXV) ? MAXV : model + n;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 after reset", 32'd0);

        // R2 latency, edge by edge
        btn_n = 1'b0;
        @(negedge clk); check("R2 edge1", 32'd0);
        @(negedge clk); check("R2 edge2", 32'd0);
        @(negedge clk); check("R2 edge3", 32'd1);
        btn_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 settled", 32'd3);

        // R3 sweep of press lengths
        for (int n = 1; n <= 20; n++) begin
            clear_cnt();
            check("R7 cleared", 32'd0);
            press(n);
            check("R3 sweep", 32'(n));
        end

        // R5 freeze and R6 resume
        clear_cnt();
        press(5);
        repeat (30) @(negedge clk);
        check("R5 frozen", 32'd5);
        press(7);
        check("R6 resume", 32'd12);

        // R8 ignored write
        @(negedge clk); wr_en = 1'b1; wr_data = 32'h7FFF_FFFF;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
        @(negedge clk);
        check("R8 no clear", 32'd12);

        // R7 clear
        clear_cnt();
        check("R7 clear", 32'd0);

        // R4 saturation
        press(70);
        check("R4 saturate", 32'(MAXV));
        press(5);
        check("R4 stay", 32'(MAXV));
        check("R10 upper zero", 32'(MAXV));
        clear_cnt();
        press(MAXV - 1);
        check("R4 below max", 32'(MAXV - 1));
        press(1);
        check("R4 reach max", 32'(MAXV));
        clear_cnt();
        press(MAXV);
        check("R4 exact max", 32'(MAXV));

        // R9 clear during an active press: expected M+2
        clear_cnt();
        @(negedge clk); btn_n = 1'b0;
        repeat (10) @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h8000_0000;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        repeat (4) @(negedge clk);
        btn_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 clear wins", 32'd6);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule